// File: doc/BRIEF.md
# Configurable Audio Serial Receiver

This block turns a two-channel serial audio stream into parallel left and right sample words. It watches three externally driven lines: a bit clock, a frame clock that tells which channel is being sent, and a serial data line. All three are brought into the system clock domain. A rising edge of the bit clock is found by comparing the current sample with the one before it. The frame clock and the data bit are taken on that same edge.

Software or a neighbouring block sets a static configuration. It chooses the framing style (I2S, MSB-justified or LSB-justified), the word length, the number of bit clocks per frame, and which frame-clock level means the left channel. The block assembles each channel's word with the MSB at the top bit of the output. Both words are presented together with a one-cycle strobe once per frame. Configuration is expected to change only while reset is asserted.

Top module: `aud_serial_rx`

## Requirements
- R1: Bits arrive MSB first; the first data bit of a word lands in output bit 23 and later bits fill downward.
- R2: The format code picks the slot of the MSB within each half-frame. Code 01 (MSB-justified) puts it on slot 0, the first bit clock after the frame-clock transition. Codes 10 and 11 (I2S) put it on slot 1. Code 00 (LSB-justified) places the word so that its last bit falls on the final slot of the half-frame.
- R3: The word-length code gives 16 bits for 00, 18 for 01, 20 for 10 and 24 for 11. Every output bit below the word, and every slot that carries no data, reads as zero, whatever was on the data line.
- R4: The frame-size code gives 32 bit clocks per frame for 00, 48 for 01, and 64 for both 10 and 11. Each half-frame is half of that.
- R5: With the polarity bit at 0, the left channel is sent while the frame clock is low. With it at 1, the left channel is sent while the frame clock is high.
- R6: The valid strobe is high for exactly one system clock per frame, after the right-channel word completes. The left and right outputs change only in that cycle.
- R7: When a word does not fit in the slots left in its half-frame, its low bits are dropped silently. An LSB-justified word longer than the half-frame starts at slot 0.
- R8: Reset clears both outputs and the strobe. No sample is reported from a half-frame that was already in progress when reset was released. The first strobe needs a complete left half followed by a complete right half.
- R9: Data and frame clock are sampled on the rising bit-clock edge, so a stream that changes on the falling edge is received intact. The strobe follows a detected rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock from the external source |
| lrclk_i | input | 1 | Frame clock marking the channel in progress |
| sdata_i | input | 1 | Serial audio data |
| cfg_fmt | input | 2 | Framing style code (R2) |
| cfg_wlen | input | 2 | Word length code (R3) |
| cfg_fsize | input | 2 | Bit clocks per frame code (R4) |
| cfg_left_high | input | 1 | Frame-clock level meaning left channel (R5) |
| left_o | output | 24 | Left sample, MSB at bit 23 |
| right_o | output | 24 | Right sample, MSB at bit 23 |
| valid_o | output | 1 | One-cycle strobe when both samples update |

## Verification
Some properties hold on every cycle, and the embedded assertions check these continuously. The strobe never lasts more than one cycle, and it always follows a detected bit-clock rise. The outputs never move without the strobe. Bits below the configured word length are always zero when the strobe fires.

Other behaviour can only be shown by the bench's scenarios, because it depends on the bit pattern of a whole stream. These are whether each bit lands in the right position for each framing style, frame size and polarity, and how overlong words are cut. The bench also confirms that a partial half-frame after reset yields nothing, and it fills every non-data slot with ones so that any leak shows.

// File: rtl/aud_rx_pkg.sv
`timescale 1ns/1ps
package aud_rx_pkg;
   localparam int SLOT_W   = 6;
   localparam int MAX_SLOT = (1 << SLOT_W) - 1;

   localparam logic [1:0] FMT_LSBJ = 2'b00;
   localparam logic [1:0] FMT_MSBJ = 2'b01;

   typedef logic [SLOT_W-1:0] slot_t;

   // word length code -> number of bits
   function automatic slot_t word_len(input logic [1:0] code);
      case (code)
         2'b00:   return slot_t'(16);
         2'b01:   return slot_t'(18);
         2'b10:   return slot_t'(20);
         default: return slot_t'(24);
      endcase
   endfunction

   // frame size code -> slots per half-frame
   function automatic slot_t half_len(input logic [1:0] code);
      case (code)
         2'b00:   return slot_t'(16);
         2'b01:   return slot_t'(24);
         default: return slot_t'(32);
      endcase
   endfunction

   // slot holding the MSB of the word
   function automatic slot_t first_slot(input logic [1:0] fmt,
                                        input slot_t wl, input slot_t hl);
      if (fmt == FMT_MSBJ) return '0;
      if (fmt[1])          return slot_t'(1);
      if (hl > wl)         return hl - wl;
      return '0;
   endfunction
endpackage

// File: rtl/aud_rx_sync.sv
`timescale 1ns/1ps
module aud_rx_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [WIDTH-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= d_i;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q_o = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/aud_rx_framer.sv
`timescale 1ns/1ps
module aud_rx_framer
   import aud_rx_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  bclk_s,
   input  logic  lr_s,
   input  logic  cfg_left_high,
   output logic  rise_o,
   output logic  change_o,
   output slot_t slot_o,
   output logic  is_left_o
);
   logic  bclk_d, lr_prev, lr_known;
   slot_t slot_q;

   assign rise_o    = bclk_s & ~bclk_d;
   assign change_o  = rise_o & lr_known & (lr_s != lr_prev);
   assign is_left_o = (lr_s == cfg_left_high);

   always_comb begin
      if (change_o)                    slot_o = '0;
      else if (slot_q == slot_t'(MAX_SLOT)) slot_o = slot_q;
      else                             slot_o = slot_q + slot_t'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_d   <= 1'b1;
         lr_prev  <= 1'b0;
         lr_known <= 1'b0;
         slot_q   <= slot_t'(MAX_SLOT);
      end else begin
         bclk_d <= bclk_s;
         if (rise_o) begin
            lr_prev  <= lr_s;
            lr_known <= 1'b1;
            slot_q   <= slot_o;
         end
      end
   end

   // R2: slot numbering restarts whenever the frame clock flips
   assert_slot_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      change_o |=> (slot_q == '0));
endmodule

// File: rtl/aud_rx_assemble.sv
`timescale 1ns/1ps
module aud_rx_assemble
   import aud_rx_pkg::*;
#(
   parameter int OUT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_i,
   input  logic             change_i,
   input  slot_t            slot_i,
   input  logic             is_left_i,
   input  logic             sd_i,
   input  logic [1:0]       cfg_fmt,
   input  logic [1:0]       cfg_wlen,
   input  logic [1:0]       cfg_fsize,
   output logic [OUT_W-1:0] left_o,
   output logic [OUT_W-1:0] right_o,
   output logic             valid_o
);
   localparam int IDX_W = $clog2(OUT_W);

   slot_t            wl, hl, st, rel;
   logic             hit;
   logic [IDX_W-1:0] pos;
   logic [OUT_W-1:0] placed, low_mask;
   logic [OUT_W-1:0] cur_word, left_hold;
   logic             cur_full, cur_left, left_ok;

   always_comb begin
      wl       = word_len(cfg_wlen);
      hl       = half_len(cfg_fsize);
      st       = first_slot(cfg_fmt, wl, hl);
      rel      = slot_i - st;
      hit      = (slot_i >= st) && (rel < wl) && (slot_i < hl);
      pos      = IDX_W'(OUT_W-1) - IDX_W'(rel);
      placed   = change_i ? '0 : cur_word;
      if (hit) placed[pos] = sd_i;
      low_mask = {OUT_W{1'b1}} >> wl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_word  <= '0;
         left_hold <= '0;
         cur_full  <= 1'b0;
         cur_left  <= 1'b0;
         left_ok   <= 1'b0;
         left_o    <= '0;
         right_o   <= '0;
         valid_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (rise_i) begin
            if (change_i) begin
               if (cur_left) begin
                  left_hold <= cur_word;
                  left_ok   <= cur_full;
               end else if (cur_full && left_ok) begin
                  left_o  <= left_hold;
                  right_o <= cur_word;
                  valid_o <= 1'b1;
                  left_ok <= 1'b0;
               end
               cur_full <= 1'b1;
            end
            cur_word <= placed;
            cur_left <= is_left_i;
         end
      end
   end

   // R3: nothing below the configured word length is ever reported
   assert_low_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (((left_o | right_o) & low_mask) == '0));
endmodule

// File: rtl/aud_serial_rx.sv
`timescale 1ns/1ps
module aud_serial_rx
   import aud_rx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int OUT_W       = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk_i,
   input  logic             lrclk_i,
   input  logic             sdata_i,
   input  logic [1:0]       cfg_fmt,
   input  logic [1:0]       cfg_wlen,
   input  logic [1:0]       cfg_fsize,
   input  logic             cfg_left_high,
   output logic [OUT_W-1:0] left_o,
   output logic [OUT_W-1:0] right_o,
   output logic             valid_o
);
   generate
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..4");
      end
      if (OUT_W < 24) begin : g_bad_width
         $error("OUT_W must hold a 24-bit word");
      end
   endgenerate

   logic [2:0] raw, synced;
   logic       rise, change, is_left;
   slot_t      slot;

   assign raw = {bclk_i, lrclk_i, sdata_i};

   aud_rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(synced));

   aud_rx_framer u_framer (
      .clk(clk), .rst_n(rst_n), .bclk_s(synced[2]), .lr_s(synced[1]),
      .cfg_left_high(cfg_left_high), .rise_o(rise), .change_o(change),
      .slot_o(slot), .is_left_o(is_left));

   aud_rx_assemble #(.OUT_W(OUT_W)) u_asm (
      .clk(clk), .rst_n(rst_n), .rise_i(rise), .change_i(change),
      .slot_i(slot), .is_left_i(is_left), .sd_i(synced[0]),
      .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .cfg_fsize(cfg_fsize),
      .left_o(left_o), .right_o(right_o), .valid_o(valid_o));

   // R6: strobe lasts a single cycle
   assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R6: outputs only move together with the strobe
   assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((left_o != $past(left_o)) || (right_o != $past(right_o))) |-> valid_o);

   // R9: a strobe is always caused by a detected bit-clock rise
   assert_valid_after_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(rise));
endmodule

// File: tb/aud_serial_rx_bench.sv
`timescale 1ns/1ps
module aud_serial_rx_bench;
   typedef struct packed {
      logic [1:0]  fmt;
      logic [1:0]  wlen;
      logic [1:0]  fsize;
      logic        pol;
      logic [23:0] l;
      logic [23:0] r;
   } vec_t;

   localparam int NV = 9;
   localparam int HB = 4;
   localparam vec_t VECS [NV] = '{
      '{2'b01, 2'b00, 2'b10, 1'b0, 24'h9A3C5E, 24'h13579B},
      '{2'b10, 2'b11, 2'b10, 1'b0, 24'hF0E1D2, 24'h0F1E2D},
      '{2'b00, 2'b01, 2'b10, 1'b1, 24'hC3A5F7, 24'h5A5A5A},
      '{2'b00, 2'b10, 2'b01, 1'b0, 24'h6B2D91, 24'hE4C871},
      '{2'b11, 2'b11, 2'b01, 1'b1, 24'hA1B2C3, 24'h3C2B1A},
      '{2'b01, 2'b11, 2'b00, 1'b1, 24'h8E7D6C, 24'h5B4A39},
      '{2'b00, 2'b11, 2'b00, 1'b0, 24'hD5E6F7, 24'h2468AC},
      '{2'b10, 2'b00, 2'b00, 1'b1, 24'hBEEF01, 24'h7E57ED},
      '{2'b01, 2'b10, 2'b11, 1'b0, 24'h55AA33, 24'hCC0F96}
   };

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        bclk = 1'b1, lrclk = 1'b0, sdata = 1'b0;
   logic [1:0]  cfg_fmt = 2'b01, cfg_wlen = 2'b00, cfg_fsize = 2'b10;
   logic        cfg_left_high = 1'b0;
   logic [23:0] left_o, right_o;
   logic        valid_o;

   int          errors = 0, checks = 0, ncap = 0, glitches = 0;
   logic [23:0] cap_l [4];
   logic [23:0] cap_r [4];
   logic [23:0] prev_l = '0, prev_r = '0;
   bit          done = 0;

   always #10 clk = ~clk;

   aud_serial_rx u_aud_serial_rx (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrclk_i(lrclk), .sdata_i(sdata),
      .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .cfg_fsize(cfg_fsize),
      .cfg_left_high(cfg_left_high), .left_o(left_o), .right_o(right_o),
      .valid_o(valid_o));

   always @(negedge clk) begin
      if (rst_n) begin
         if (valid_o) begin
            if (ncap < 4) begin
               cap_l[ncap] = left_o;
               cap_r[ncap] = right_o;
            end
            ncap++;
         end else if (left_o != prev_l || right_o != prev_r) begin
            glitches++;
         end
      end
      prev_l = left_o;
      prev_r = right_o;
   end

   task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int wbits(input logic [1:0] c);
      return (c == 2'b00) ? 16 : (c == 2'b01) ? 18 : (c == 2'b10) ? 20 : 24;
   endfunction
   function automatic int hslots(input logic [1:0] c);
      return (c == 2'b00) ? 16 : (c == 2'b01) ? 24 : 32;
   endfunction
   function automatic int start_slot(input vec_t v);
      int w = wbits(v.wlen);
      int h = hslots(v.fsize);
      if (v.fmt == 2'b01) return 0;
      if (v.fmt[1])       return 1;
      return (h > w) ? h - w : 0;
   endfunction
   function automatic logic [23:0] expect_word(input vec_t v, input logic [23:0] s);
      int w   = wbits(v.wlen);
      int fit = hslots(v.fsize) - start_slot(v);
      if (w < fit) fit = w;
      return s & ~(24'hFFFFFF >> fit);
   endfunction

   task automatic slot_out(input logic lr, input logic sd);
      @(negedge clk);
      bclk = 1'b0; lrclk = lr; sdata = sd;
      repeat (HB - 1) @(negedge clk);
      @(negedge clk);
      bclk = 1'b1;
      repeat (HB - 1) @(negedge clk);
   endtask

   // non-data slots carry ones so any leak into the output shows
   task automatic send_half(input vec_t v, input bit left, input logic [23:0] s);
      int w  = wbits(v.wlen);
      int st = start_slot(v);
      logic lr = left ? v.pol : ~v.pol;
      for (int slot = 0; slot < hslots(v.fsize); slot++) begin
         int k = slot - st;
         slot_out(lr, (k >= 0 && k < w) ? s[23-k] : 1'b1);
      end
   endtask

   task automatic run_vec(input int idx, input vec_t v);
      rst_n = 1'b0;
      cfg_fmt = v.fmt; cfg_wlen = v.wlen; cfg_fsize = v.fsize;
      cfg_left_high = v.pol;
      bclk = 1'b1; lrclk = ~v.pol; sdata = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      ncap = 0;
      if (idx == 0) begin
         check("R8 reset left", left_o, 24'h0);
         check("R8 reset right", right_o, 24'h0);
         check("R8 reset valid", {23'b0, valid_o}, 24'h0);
      end
      for (int p = 0; p < 3; p++) slot_out(~v.pol, 1'b1);
      send_half(v, 1'b1, v.l);
      send_half(v, 1'b0, v.r);
      send_half(v, 1'b1, ~v.l);
      send_half(v, 1'b0, ~v.r);
      send_half(v, 1'b1, 24'h0);
      repeat (8) @(negedge clk);
      $display("vector %0d fmt=%b wlen=%b fsize=%b pol=%b", idx, v.fmt, v.wlen, v.fsize, v.pol);
      check("R8/R6 strobes per run", 24'(ncap), 24'd2);
      if (ncap >= 2) begin
         check("R1/R2/R3/R4/R5/R7 left frame1", cap_l[0], expect_word(v, v.l));
         check("R1/R2/R3/R4/R5/R7 right frame1", cap_r[0], expect_word(v, v.r));
         check("R1/R2/R3/R9 left frame2", cap_l[1], expect_word(v, ~v.l));
         check("R1/R2/R3/R9 right frame2", cap_r[1], expect_word(v, ~v.r));
      end
   endtask

   initial begin
      for (int v = 0; v < NV; v++) run_vec(v, VECS[v]);
      check("R6 outputs held between strobes", 24'(glitches), 24'd0);
      // R8: reset in mid-stream clears reported samples
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R8 reset clears left", left_o, 24'h0);
      check("R8 reset clears right", right_o, 24'h0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule